// File: doc/BRIEF.md
# Three-Digit Decimal Ripple Counter

This block counts falling edges of a single count input and shows the total as three decimal digits: units, tens and hundreds. Each digit is a decade stage of four flip-flops that steps through 0 to 9 and then returns to 0. The stages are chained by rippling. The most significant bit of a lower decade is the clock of the next decade. The tens digit therefore advances when the units digit falls from 9 to 0, and the hundreds digit advances when the tens digit does the same. There is no shared clock and no carry or enable chain.

Inside a decade, each flip-flop has its own clock. The lowest bit toggles on the stage input. Bits one and three are clocked by the lowest bit falling. Bit two is clocked by bit one falling. The data inputs are chosen so that the stage skips the six codes above 9. The full range is 000 to 999, and the count after 999 is 000. An asynchronous reset clears all three digits together. The digits settle after a short ripple following each counting edge, so a reader samples them once that ripple has died out.

Top module: `bcd_ripple_counter`

## Requirements
- R1: While `rst_i` is high, all three digits read 0. The clear takes effect without waiting for any edge of `cnt_i`.
- R2: Each falling edge of `cnt_i` outside reset adds one to the count. Rising edges of `cnt_i` leave all digits unchanged.
- R3: Every digit is a 4-bit 8-4-2-1 binary code with bit 3 as the most significant bit. No digit ever holds a value from 10 to 15.
- R4: The units digit goes from 9 to 0. The tens digit advances by one exactly when this happens (for example 009 becomes 010). At any other count the tens digit holds.
- R5: The hundreds digit advances by one exactly when the tens digit wraps from 9 to 0 (for example 099 becomes 100). At any other count the hundreds digit holds.
- R6: The count that follows 999 is 000.
- R7: After N falling edges since reset, 100·hundreds + 10·tens + units equals N mod 1000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cnt_i | input | 1 | Count input. Falling edges are counted. |
| rst_i | input | 1 | Asynchronous reset, active high. |
| units_o | output | 4 | Units digit in BCD. |
| tens_o | output | 4 | Tens digit in BCD. |
| hundreds_o | output | 4 | Hundreds digit in BCD. |

## Verification
The checker samples on each rising edge of the count input, halfway between counting edges. On every cycle it checks that all digits are in range and that the units digit steps by one from the previous sample. It also checks that a higher digit moves only when the digit below it has just wrapped, that 999 is followed by 000, and that the digits read zero under reset. Some behaviour only the bench's scenarios can show. These are the total count against a decimal reference model over more than a full cycle of 1000, and a reset applied in the middle of counting. The bench also samples just after a rising edge to show that rising edges change nothing.

// File: rtl/bcd_ripple_pkg.sv
package bcd_ripple_pkg;

    localparam int DIGIT_W     = 4;
    localparam int NUM_DECADES = 3;
    localparam int DIGIT_MAX   = 9;

    typedef logic [DIGIT_W-1:0] digit_t;

    // Per-flip-flop data inputs of one decade, msb first
    typedef struct packed {
        logic b3;
        logic b2;
        logic b1;
        logic b0;
    } decade_bits_t;

endpackage

// File: rtl/bcd_neg_dff.sv
module bcd_neg_dff (
    input  logic tick_i,
    input  logic rst_i,
    input  logic d_i,
    output logic q_o
);

    always_ff @(negedge tick_i or posedge rst_i) begin
        if (rst_i) begin
            q_o <= 1'b0;
        end else begin
            q_o <= d_i;
        end
    end

endmodule

// File: rtl/bcd_decade_stage.sv
module bcd_decade_stage
    import bcd_ripple_pkg::*;
(
    input  logic   tick_i,
    input  logic   rst_i,
    output digit_t digit_o
);

    localparam int NBITS = DIGIT_W;

    logic [NBITS-1:0] bits_q;
    decade_bits_t     bits_d;
    logic [NBITS-1:0] d_vec;
    logic [NBITS-1:0] clk_sel;

    // Next values of every flip-flop. Each is consulted only on its own clock edge.
    always_comb begin
        bits_d    = '0;
        // bit0 toggles on every stage input edge
        bits_d.b0 = ~bits_q[0];
        // bit1 toggles unless the decade is at 8/9 (stops 9 -> 10)
        bits_d.b1 = ~bits_q[1] & ~bits_q[3];
        // bit2 toggles on each fall of bit1
        bits_d.b2 = ~bits_q[2];
        // bit3 set when leaving 7, cleared when leaving 9
        bits_d.b3 = bits_q[1] & bits_q[2];
    end

    // Clock selection per flip-flop
    always_comb begin
        clk_sel    = '0;
        clk_sel[0] = tick_i;
        clk_sel[1] = bits_q[0];
        clk_sel[2] = bits_q[1];
        clk_sel[3] = bits_q[0];
        d_vec      = bits_d;
    end

    for (genvar gi = 0; gi < NBITS; gi++) begin : g_ff
        bcd_neg_dff u_ff (
            .tick_i (clk_sel[gi]),
            .rst_i  (rst_i),
            .d_i    (d_vec[gi]),
            .q_o    (bits_q[gi])
        );
    end

    assign digit_o = bits_q;

endmodule

// File: rtl/bcd_ripple_counter.sv
module bcd_ripple_counter
    import bcd_ripple_pkg::*;
(
    input  logic                cnt_i,
    input  logic                rst_i,
    output logic [DIGIT_W-1:0]  units_o,
    output logic [DIGIT_W-1:0]  tens_o,
    output logic [DIGIT_W-1:0]  hundreds_o
);

    localparam int MSB = DIGIT_W - 1;

    digit_t                 digit_q [NUM_DECADES];
    logic [NUM_DECADES-1:0] stage_clk;

    // Stage 0 takes the count input; every higher stage takes the MSB of the stage below
    always_comb begin
        stage_clk[0] = cnt_i;
        for (int k = 1; k < NUM_DECADES; k++) begin
            stage_clk[k] = digit_q[k-1][MSB];
        end
    end

    for (genvar gs = 0; gs < NUM_DECADES; gs++) begin : g_dec
        bcd_decade_stage u_stage (
            .tick_i  (stage_clk[gs]),
            .rst_i   (rst_i),
            .digit_o (digit_q[gs])
        );
    end

    assign units_o    = digit_q[0];
    assign tens_o     = digit_q[1];
    assign hundreds_o = digit_q[2];

endmodule

// File: rtl/bcd_ripple_counter_chk.sv
module bcd_ripple_counter_chk
    import bcd_ripple_pkg::*;
(
    input logic               cnt_i,
    input logic               rst_i,
    input logic [DIGIT_W-1:0] units_o,
    input logic [DIGIT_W-1:0] tens_o,
    input logic [DIGIT_W-1:0] hundreds_o
);

    // Sampling on the rising edge, midway between counting edges, once the ripple has settled
    a_r1_reset_clear: assert property (@(posedge cnt_i)
        rst_i |-> (units_o == '0 && tens_o == '0 && hundreds_o == '0));

    a_r3_digit_range: assert property (@(posedge cnt_i) disable iff (rst_i)
        (units_o <= 4'd9 && tens_o <= 4'd9 && hundreds_o <= 4'd9));

    a_r2_units_step: assert property (@(posedge cnt_i) disable iff (rst_i)
        ($past(units_o) != 4'd9) |-> (units_o == $past(units_o) + 4'd1));

    a_r4_tens_hold: assert property (@(posedge cnt_i) disable iff (rst_i)
        ($past(units_o) != 4'd9) |-> (tens_o == $past(tens_o)));

    a_r4_units_wrap: assert property (@(posedge cnt_i) disable iff (rst_i)
        ($past(units_o) == 4'd9) |-> (units_o == 4'd0));

    a_r5_hundreds_hold: assert property (@(posedge cnt_i) disable iff (rst_i)
        !($past(units_o) == 4'd9 && $past(tens_o) == 4'd9) |-> (hundreds_o == $past(hundreds_o)));

    a_r6_full_wrap: assert property (@(posedge cnt_i) disable iff (rst_i)
        ($past(units_o) == 4'd9 && $past(tens_o) == 4'd9 && $past(hundreds_o) == 4'd9)
        |-> (units_o == 4'd0 && tens_o == 4'd0 && hundreds_o == 4'd0));

endmodule

bind bcd_ripple_counter bcd_ripple_counter_chk u_chk (
    .cnt_i      (cnt_i),
    .rst_i      (rst_i),
    .units_o    (units_o),
    .tens_o     (tens_o),
    .hundreds_o (hundreds_o)
);

// File: tb/bcd_ripple_counter_test.sv
`timescale 1ns/1ps
module bcd_ripple_counter_test;

    logic       cnt_i = 1'b1;
    logic       rst_i = 1'b1;
    logic [3:0] units_o, tens_o, hundreds_o;

    int n_checks = 0;
    int n_fails  = 0;
    int ref_cnt  = 0;
    bit done     = 0;

    bcd_ripple_counter uut (
        .cnt_i      (cnt_i),
        .rst_i      (rst_i),
        .units_o    (units_o),
        .tens_o     (tens_o),
        .hundreds_o (hundreds_o)
    );

    always #5 cnt_i = ~cnt_i;   // 100 MHz

    // {edges since reset, expected hundreds, tens, units}
    localparam int NVEC = 16;
    localparam int VEC [NVEC][4] = '{
        '{1, 0,0,1}, '{9, 0,0,9}, '{10, 0,1,0}, '{11, 0,1,1},
        '{99, 0,9,9}, '{100, 1,0,0}, '{109, 1,0,9}, '{110, 1,1,0},
        '{199, 1,9,9}, '{200, 2,0,0}, '{505, 5,0,5}, '{998, 9,9,8},
        '{999, 9,9,9}, '{1000, 0,0,0}, '{1001, 0,0,1}, '{1005, 0,0,5}
    };

    task automatic check(string req, int h, int t, int u);
        n_checks++;
        if (hundreds_o != h[3:0] || tens_o != t[3:0] || units_o != u[3:0]) begin
            n_fails++;
            $display("FAIL %s: got %0d%0d%0d expected %0d%0d%0d at ref %0d",
                     req, hundreds_o, tens_o, units_o, h, t, u, ref_cnt);
        end
    endtask

    // R7 reference: digits of the model count
    task automatic check_ref(string req);
        int m;
        m = ref_cnt % 1000;
        check(req, m / 100, (m / 10) % 10, m % 10);
    endtask

    // one counting edge, then sample after the following rising edge (R2: rising edge has no effect)
    task automatic step();
        @(negedge cnt_i);
        ref_cnt++;
        #2;
        check_ref("R7");
        @(posedge cnt_i);
        #1;
        check_ref("R2");
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(posedge cnt_i);
        #1;
        check("R1", 0, 0, 0);
        #1;
        rst_i = 1'b0;
        ref_cnt = 0;

        // vector table walk; every count compared against the model (R3..R7)
        for (int v = 0; v < NVEC; v++) begin
            while (ref_cnt < VEC[v][0]) step();
            case (VEC[v][0])
                10, 110:  check("R4", VEC[v][1], VEC[v][2], VEC[v][3]);
                100, 200: check("R5", VEC[v][1], VEC[v][2], VEC[v][3]);
                1000:     check("R6", VEC[v][1], VEC[v][2], VEC[v][3]);
                default:  check("R3", VEC[v][1], VEC[v][2], VEC[v][3]);
            endcase
        end

        // R1: asynchronous reset mid-count, between edges
        repeat (37) step();
        @(posedge cnt_i);
        #2;
        rst_i = 1'b1;
        #1;
        check("R1", 0, 0, 0);
        @(negedge cnt_i);
        #2;
        check("R1", 0, 0, 0);
        @(posedge cnt_i);
        #2;
        rst_i = 1'b0;
        ref_cnt = 0;
        repeat (3) step();
        check("R1", 0, 0, 3);

        // R4/R5 directed: 009 -> 010 and 099 -> 100 from fresh reset
        while (ref_cnt < 9) step();
        check("R4", 0, 0, 9);
        step();
        check("R4", 0, 1, 0);
        while (ref_cnt < 99) step();
        step();
        check("R5", 1, 0, 0);

        done = 1;
        summary();
    end

endmodule